// File: doc/BRIEF.md
# Single-Wire Debug Target Bit Engine

This block is the target end of a one-line debug link. The line is open-drain with an external pull-up. The host starts every bit by pulling the line low. The target counts its own clock cycles from the falling edge it sees, and then does one of two things:

- For a host-to-target bit, it samples the line at a fixed point in the bit.
- For a target-to-host bit, it answers a zero by holding the line low for a fixed time, then drives a one-cycle high pulse to sharpen the rising edge.

Bits are gathered into bytes in a single shift register. A command decoder beside the block loads a byte when it wants that byte sent back, and it collects received bytes on a one-cycle strobe. The same register and strobe serve both directions. During a transmitted byte, the bits read back from the line are shifted in, so at the strobe the register holds what actually appeared on the wire.

Top module: `dbgw_phy`

## Requirements
- R1: After reset, `wire_oe`, `wire_drv` and `byte_done` are 0, `rx_data` is 0x00, and the block is in receive mode.
- R2: A falling edge of the synchronized line, seen while no bit is in progress, starts a bit period of BIT_CYCLES (16) cycles. Further falling edges inside that period are ignored.
- R3: In receive mode, the bit value is the synchronized line level SAMPLE_AT (10) cycles after the start edge. A short host low (3 cycles) gives 1 and a long host low (14 cycles) gives 0.
- R4: Bits are shifted in most-significant first. After the eighth bit, `byte_done` is high for exactly one cycle, and in that cycle `rx_data` holds the byte (first bit in bit 7).
- R5: A `tx_load` pulse while no bit is in progress loads `tx_data` and selects transmit mode for the next 8 bits. A `tx_load` during a bit period is ignored, and the block stays in receive mode.
- R6: In transmit mode, a 0 bit makes the block drive the line low (`wire_oe`=1, `wire_drv`=0) for exactly LOW_CYCLES (13) consecutive cycles, beginning the cycle after the start edge is detected.
- R7: Straight after that low time, the block drives the line high (`wire_oe`=1, `wire_drv`=1) for exactly one cycle and then releases it. The high drive never occurs except directly after the low drive.
- R8: In transmit mode, a 1 bit leaves `wire_oe` at 0 for the whole bit.
- R9: In receive mode, `wire_oe` stays 0.
- R10: At the `byte_done` of a transmitted byte, `rx_data` equals the transmitted byte as read back from the line. The block then returns to receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wire_in | input | 1 | Pad input level (asynchronous) |
| wire_oe | output | 1 | Pad output enable |
| wire_drv | output | 1 | Level driven when `wire_oe` is 1 |
| tx_load | input | 1 | Load `tx_data` for transmission |
| tx_data | input | DATA_W | Byte to transmit |
| rx_data | output | DATA_W | Shift register contents; a complete byte when `byte_done` is 1 |
| byte_done | output | 1 | One-cycle strobe after the eighth bit |

## Verification
The checker assumes that the host never starts a new bit before the previous bit period has ended. It also assumes that the host has released the line well before the target's high pulse; otherwise the low-run and high-pulse properties would describe contention rather than protocol. The bench keeps to this by giving every bit a 20-cycle slot, holding its low for at most 14 cycles, and pulling low for only 2 cycles on bits it reads back. The only falls inside a bit period are deliberate short glitches that end before the sample point, and these test the ignore rule.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_BIT  = 1'b1
  } phase_t;
endpackage

// File: rtl/dbgw_sync.sv
module dbgw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pad_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = last_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dbgw_timer.sv
module dbgw_timer
  import dbgw_pkg::*;
#(
  parameter int BIT_CYCLES = 16,
  parameter int SAMPLE_AT  = 10,
  parameter int CW         = $clog2(BIT_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_i,
  output logic          start_o,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          sample_o
);
  phase_t        ph_q;
  logic [CW-1:0] cnt_q;

  assign start_o  = (ph_q == PH_IDLE) && fall_i;
  assign busy_o   = (ph_q == PH_BIT);
  assign cnt_o    = cnt_q;
  assign sample_o = (ph_q == PH_BIT) && (cnt_q == CW'(SAMPLE_AT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (fall_i) begin
            ph_q  <= PH_BIT;
            cnt_q <= CW'(1);
          end
        end
        default: begin
          if (cnt_q == CW'(BIT_CYCLES - 1)) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbgw_shift.sv
module dbgw_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sample_i,
  input  logic              level_i,
  output logic              msb_o,
  output logic              tx_mode_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              done_o
);
  localparam int BCW = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [BCW-1:0]    nb_q;
  logic              tx_q;
  logic              done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      nb_q   <= '0;
      tx_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        sh_q <= load_data_i;
        nb_q <= '0;
        tx_q <= 1'b1;
      end else if (sample_i) begin
        sh_q <= {sh_q[DATA_W-2:0], level_i};
        if (nb_q == BCW'(DATA_W - 1)) begin
          nb_q   <= '0;
          done_q <= 1'b1;
          tx_q   <= 1'b0;
        end else begin
          nb_q <= nb_q + BCW'(1);
        end
      end
    end
  end

  assign msb_o     = sh_q[DATA_W-1];
  assign tx_mode_o = tx_q;
  assign rx_byte_o = sh_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dbgw_drive.sv
module dbgw_drive #(
  parameter int LOW_CYCLES = 13,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          tx_mode_i,
  input  logic          bit_i,
  output logic          oe_o,
  output logic          drv_o
);
  logic        zero_q;
  logic        oe_q;
  logic        drv_q;
  logic [CW:0] nxt;

  assign nxt = {1'b0, cnt_i} + (CW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q <= 1'b0;
      oe_q   <= 1'b0;
      drv_q  <= 1'b0;
    end else if (start_i) begin
      zero_q <= tx_mode_i & ~bit_i;
      oe_q   <= tx_mode_i & ~bit_i;
      drv_q  <= 1'b0;
    end else if (busy_i && zero_q && (nxt <= (CW+1)'(LOW_CYCLES))) begin
      oe_q  <= 1'b1;
      drv_q <= 1'b0;
    end else if (busy_i && zero_q && (nxt == (CW+1)'(LOW_CYCLES + 1))) begin
      oe_q  <= 1'b1;
      drv_q <= 1'b1;
    end else begin
      oe_q  <= 1'b0;
      drv_q <= 1'b0;
    end
  end

  assign oe_o  = oe_q;
  assign drv_o = drv_q;
endmodule

// File: rtl/dbgw_phy.sv
module dbgw_phy #(
  parameter int DATA_W      = 8,
  parameter int BIT_CYCLES  = 16,
  parameter int SAMPLE_AT   = 10,
  parameter int LOW_CYCLES  = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wire_in,
  output logic              wire_oe,
  output logic              wire_drv,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              byte_done
);
  localparam int CW = $clog2(BIT_CYCLES);

  logic          level;
  logic          fall;
  logic          start;
  logic          busy;
  logic [CW-1:0] cnt;
  logic          sample;
  logic          msb;
  logic          tx_mode;
  logic          load_ok;

  assign load_ok = tx_load & ~busy & ~start;

  dbgw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_i(wire_in), .level_o(level), .fall_o(fall)
  );

  dbgw_timer #(.BIT_CYCLES(BIT_CYCLES), .SAMPLE_AT(SAMPLE_AT), .CW(CW)) u_timer (
    .clk(clk), .rst(rst), .fall_i(fall), .start_o(start), .busy_o(busy),
    .cnt_o(cnt), .sample_o(sample)
  );

  dbgw_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(load_ok), .load_data_i(tx_data),
    .sample_i(sample), .level_i(level), .msb_o(msb), .tx_mode_o(tx_mode),
    .rx_byte_o(rx_data), .done_o(byte_done)
  );

  dbgw_drive #(.LOW_CYCLES(LOW_CYCLES), .CW(CW)) u_drive (
    .clk(clk), .rst(rst), .start_i(start), .busy_i(busy), .cnt_i(cnt),
    .tx_mode_i(tx_mode), .bit_i(msb), .oe_o(wire_oe), .drv_o(wire_drv)
  );
endmodule

// File: rtl/dbgw_phy_chk.sv
module dbgw_phy_chk #(
  parameter int BIT_CYCLES = 16,
  parameter int LOW_CYCLES = 13
) (
  input logic clk,
  input logic rst,
  input logic wire_oe,
  input logic wire_drv,
  input logic byte_done,
  input logic tx_mode
);
  logic [15:0] low_run;
  logic [15:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
      quiet   <= '0;
    end else begin
      low_run <= (wire_oe && !wire_drv) ? low_run + 16'd1 : 16'd0;
      if (tx_mode) quiet <= '0;
      else if (quiet != 16'hFFFF) quiet <= quiet + 16'd1;
    end
  end

  p_low_limit_r6: assert property (@(posedge clk) disable iff (rst)
    low_run <= 16'(LOW_CYCLES));

  p_high_needs_oe_r7: assert property (@(posedge clk) disable iff (rst)
    wire_drv |-> wire_oe);

  p_high_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (wire_oe && wire_drv) |=> !(wire_oe && wire_drv));

  p_high_after_low_r7: assert property (@(posedge clk) disable iff (rst)
    (wire_oe && wire_drv) |-> $past(wire_oe && !wire_drv));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> !byte_done);

  p_rx_silent_r9: assert property (@(posedge clk) disable iff (rst)
    (quiet >= 16'(BIT_CYCLES)) |-> !wire_oe);
endmodule

bind dbgw_phy dbgw_phy_chk #(.BIT_CYCLES(BIT_CYCLES), .LOW_CYCLES(LOW_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .wire_oe(wire_oe), .wire_drv(wire_drv),
  .byte_done(byte_done), .tx_mode(tx_mode)
);

// File: tb/tb_dbgw_phy.sv
module tb_dbgw_phy;
  localparam int SLOT = 20;
  localparam int LOWN = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_low = 1'b0;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       wire_oe, wire_drv, byte_done;
  logic [7:0] rx_data;
  logic       pad;

  int checks = 0;
  int errors = 0;
  int low_cnt = 0, up_cnt = 0, oe_cnt = 0, order_bad = 0, done_cnt = 0;
  logic prev_low = 1'b0;
  logic [7:0] got = 8'h00;

  always #2.5 clk = ~clk;

  assign pad = host_low ? 1'b0 : (wire_oe ? wire_drv : 1'b1);

  dbgw_phy dut (
    .clk(clk), .rst(rst), .wire_in(pad), .wire_oe(wire_oe), .wire_drv(wire_drv),
    .tx_load(tx_load), .tx_data(tx_data), .rx_data(rx_data), .byte_done(byte_done)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (wire_oe && !wire_drv) low_cnt++;
      if (wire_oe && wire_drv) begin
        up_cnt++;
        if (!prev_low) order_bad++;
      end
      if (wire_oe) oe_cnt++;
      prev_low = wire_oe && !wire_drv;
      if (byte_done) begin
        done_cnt++;
        got = rx_data;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic host_bit(input int low_len, input int glitch_at, input bit load_mid);
    for (int c = 0; c < SLOT; c++) begin
      @(negedge clk);
      host_low = (c < low_len) || (glitch_at > 0 && (c == glitch_at || c == glitch_at + 1));
      tx_load  = load_mid && (c == 6);
      if (load_mid && c == 6) tx_data = 8'h00;
    end
    @(negedge clk);
    host_low = 1'b0;
    tx_load  = 1'b0;
    #1;
  endtask

  // R2 R3 R4 R9: host writes a byte; optional glitches on 1 bits; optional load mid-bit (R5)
  task automatic test_write(input logic [7:0] b, input bit glitch, input bit load_mid, input string tag);
    int d0, o0;
    d0 = done_cnt; o0 = oe_cnt;
    for (int i = 7; i >= 0; i--)
      host_bit(b[i] ? 3 : 14, (glitch && b[i]) ? 5 : 0, load_mid && (i == 7));
    chk(done_cnt - d0 == 1, {tag, " R4 one strobe per byte"}, done_cnt - d0, 1);
    chk(got == b, {tag, " R3 received byte"}, got, b);
    chk(oe_cnt == o0, {tag, " R9 no drive in receive"}, oe_cnt - o0, 0);
  endtask

  // R5 R6 R7 R8 R10: host reads a byte
  task automatic test_read(input logic [7:0] b);
    int d0, l0, u0, o0, ob0;
    @(negedge clk);
    tx_load = 1'b1; tx_data = b;
    @(negedge clk);
    tx_load = 1'b0;
    d0 = done_cnt;
    for (int i = 7; i >= 0; i--) begin
      l0 = low_cnt; u0 = up_cnt; o0 = oe_cnt; ob0 = order_bad;
      host_bit(2, 0, 1'b0);
      if (!b[i]) begin
        chk(low_cnt - l0 == LOWN, "R6 low drive length", low_cnt - l0, LOWN);
        chk(up_cnt - u0 == 1, "R7 high pulse count", up_cnt - u0, 1);
        chk(order_bad == ob0, "R7 high follows low", order_bad - ob0, 0);
      end else begin
        chk(oe_cnt == o0, "R8 no drive for one", oe_cnt - o0, 0);
      end
    end
    chk(done_cnt - d0 == 1, "R10 strobe after transmit", done_cnt - d0, 1);
    chk(got == b, "R10 read-back byte", got, b);
  endtask

  task automatic test_reset();
    repeat (4) @(negedge clk);
    chk(wire_oe == 1'b0, "R1 oe at reset", wire_oe, 0);
    chk(wire_drv == 1'b0, "R1 drv at reset", wire_drv, 0);
    chk(byte_done == 1'b0, "R1 strobe at reset", byte_done, 0);
    chk(rx_data == 8'h00, "R1 data at reset", rx_data, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    #1;
  endtask

  initial begin
    test_reset();
    test_write(8'hA5, 1'b0, 1'b0, "w A5");
    test_write(8'h00, 1'b0, 1'b0, "w 00");
    test_write(8'hFF, 1'b0, 1'b0, "w FF");
    test_write(8'h3C, 1'b1, 1'b0, "R2 glitch 3C");
    test_write(8'hC3, 1'b0, 1'b1, "R5 load while busy");
    test_read(8'h5A);
    test_read(8'h81);
    test_write(8'h96, 1'b0, 1'b0, "R10 back to receive");
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    summary();
    $finish;
  end
endmodule